// File: doc/BRIEF.md
# Periodic Interval Timer with Elapsed-Period Counter

This block is a register-mapped time base. A fixed divide-by-16 stage turns the system clock into counter ticks. A 20-bit counter climbs from zero to a programmed limit, then returns to zero. Each return to zero is one completed period. A period raises a sticky status flag and adds one to a 12-bit count of elapsed periods. The interrupt line is the status flag gated by an interrupt-enable bit.

Software reads the elapsed-period count and the live counter value together in one word. Two addresses give this word. One read consumes it: the flag is acknowledged and the count restarts from zero. The other read only samples it, so the timer also works as a free-running time base with the interrupt masked. When software clears the enable bit, the counter does not stop at once. It runs on until it next returns to zero and then holds there. Software can poll for a zero counter value to know the timer has stopped.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset, every readable register returns zero, the timer is stopped and `irq` is low.
- R2: Offset 0x0 is the mode register. Bits [19:0] hold the interval value, bit 24 enables counting and bit 25 enables the interrupt. A read returns these fields, with all other bits reading zero.
- R3: While running, the counter advances by one every 16 clock cycles, from zero up to the interval value, and then returns to zero. A period therefore lasts 16 × (interval + 1) cycles. After the mode write that enables a stopped timer, the first return to zero happens 16 × (interval + 1) cycles after that write's clock edge.
- R4: Offset 0x4 bit 0 is the status flag. It is set on every return to zero and stays set until it is acknowledged.
- R5: Offsets 0x8 and 0xC both return the elapsed-period count in bits [31:20] and the live counter value in bits [19:0].
- R6: A read at 0x8 clears the status flag and the period count. If a return to zero happens on that same edge, the flag stays set and the count becomes 1.
- R7: A read at 0xC changes no state.
- R8: The period count holds at 4095 instead of wrapping.
- R9: `irq` is high exactly while the status flag and the interrupt-enable bit are both set. It is a level that drops only through an acknowledge or a cleared enable bit.
- R10: With the enable bit clear, the counter keeps advancing while it is nonzero. This includes the return to zero, which counts as a period. Once the counter is zero, the counter and the divider hold at zero.
- R11: A mode write while running applies the new interval from the next tick. If the counter is already at or above the new interval, the next tick returns it to zero.
- R12: Writes to 0x4, 0x8 and 0xC are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 4 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, takes effect on the clock edge |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; read side effects take place on the clock edge |
| rd_data | output | 32 | Read data, valid in the cycle `rd_en` is high, zero otherwise |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check several rules on every cycle. The counter moves only on a divider tick, and then by exactly one step below the limit. A raised flag always traces back to a tick. A saturated count stays put. An acknowledge clears the flag and count. A stopped counter stays at zero. Writes to read-only offsets leave the mode fields alone. The interrupt stays low while masked.

Only the bench scenarios can show the exact period length for several intervals and the latency of an interval change in mid-period. They also show the run-on to zero after disable, saturation after four thousand periods, and that the sampling window leaves state untouched while the acknowledging window does not.

// File: rtl/itt_pkg.sv
// Shared constants for the interval tick timer: register offsets and
// mode-register bit positions. Assumes a 32-bit data bus.
package itt_pkg;
    localparam int OFS_MODE  = 'h0;   // interval, enable, interrupt enable
    localparam int OFS_STAT  = 'h4;   // sticky period flag
    localparam int OFS_VACK  = 'h8;   // count/value, acknowledging read
    localparam int OFS_VPEEK = 'hC;   // count/value, side-effect-free read
    localparam int BIT_EN    = 24;    // mode: counting enable
    localparam int BIT_IEN   = 25;    // mode: interrupt enable
    localparam int DIV_RATIO = 16;    // fixed prescale ratio
endpackage

// File: rtl/itt_prescaler.sv
// Fixed-ratio clock divider for the tick timer. Emits a one-cycle tick
// every DIV cycles while run is high; returns to phase zero whenever run
// is low, so a restarted timer always sees a full first tick interval.
module itt_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Phase counter: advances while running, parks at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = run && (phase == LAST);
endmodule

// File: rtl/itt_counter.sv
// Interval counter. Steps once per tick from zero up to the interval value,
// then wraps to zero and flags the wrap. Keeps running after the enable
// drops until it sits at zero. Assumes tick is only high while run is high.
module itt_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] value,
    output logic             run,
    output logic             wrap
);
    // Running while enabled, or until a disabled counter reaches zero.
    assign run  = enable || (value != '0);
    // Compare with >= so a lowered interval ends the period at the next tick.
    assign wrap = tick && (value >= interval);

    // Counter register: wrap to zero or step by one on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wrap) begin
            value <= '0;
        end else if (tick) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/itt_regs.sv
// Register file of the tick timer: mode register, sticky status flag,
// saturating period count, read decode and the acknowledging read.
// Assumes single-cycle accesses with combinational read data.
module itt_regs
    import itt_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int PER_W  = 12,
    parameter int ADDR_W = 4,
    localparam int DATA_W = CNT_W + PER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wrap,
    input  logic [CNT_W-1:0]  value,
    output logic [CNT_W-1:0]  interval,
    output logic              enable,
    output logic              irq_en,
    output logic              status,
    output logic [PER_W-1:0]  periods,
    output logic              ack
);
    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_VACK  = ADDR_W'(OFS_VACK);
    localparam logic [ADDR_W-1:0] A_VPEEK = ADDR_W'(OFS_VPEEK);

    logic mode_wr;
    logic wr_unused;

    assign mode_wr   = wr_en && (addr == A_MODE);
    assign ack       = rd_en && (addr == A_VACK);
    assign wr_unused = ^{wr_data[DATA_W-1:BIT_IEN+1], wr_data[BIT_EN-1:CNT_W]};

    // Mode register: interval and the two enable bits, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval <= '0;
            enable   <= 1'b0;
            irq_en   <= 1'b0;
        end else if (mode_wr) begin
            interval <= wr_data[CNT_W-1:0];
            enable   <= wr_data[BIT_EN];
            irq_en   <= wr_data[BIT_IEN];
        end
    end

    // Status flag: set by a wrap, cleared by an acknowledge; a wrap wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (wrap) begin
            status <= 1'b1;
        end else if (ack) begin
            status <= 1'b0;
        end
    end

    // Period count: saturating increment per wrap, restarted by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periods <= '0;
        end else if (wrap) begin
            if (ack) begin
                periods <= PER_W'(1);
            end else if (periods != PER_MAX) begin
                periods <= periods + 1'b1;
            end
        end else if (ack) begin
            periods <= '0;
        end
    end

    // Read decode: returns zero outside a read or at an unmapped offset.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                A_MODE: begin
                    rd_data[CNT_W-1:0] = interval;
                    rd_data[BIT_EN]    = enable;
                    rd_data[BIT_IEN]   = irq_en;
                end
                A_STAT:           rd_data[0] = status;
                A_VACK, A_VPEEK:  rd_data    = {periods, value};
                default:          rd_data    = '0;
            endcase
        end
    end
endmodule

// File: rtl/interval_tick_timer.sv
// Top of the periodic interval timer. Connects the divider, the interval
// counter and the register file, and forms the level interrupt.
// Assumes DATA_W (count + value width) is wide enough for the mode bits.
module interval_tick_timer
    import itt_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int PER_W  = 12,
    parameter int ADDR_W = 4,
    localparam int DATA_W = CNT_W + PER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic             tick;
    logic             run;
    logic             wrap;
    logic             ack;
    logic             enable;
    logic             irq_en;
    logic             status;
    logic [PER_W-1:0] periods;
    logic [CNT_W-1:0] value;
    logic [CNT_W-1:0] interval;

    itt_prescaler #(
        .DIV (DIV_RATIO)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    itt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .enable   (enable),
        .interval (interval),
        .value    (value),
        .run      (run),
        .wrap     (wrap)
    );

    itt_regs #(
        .CNT_W  (CNT_W),
        .PER_W  (PER_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .wrap     (wrap),
        .value    (value),
        .interval (interval),
        .enable   (enable),
        .irq_en   (irq_en),
        .status   (status),
        .periods  (periods),
        .ack      (ack)
    );

    // Level interrupt: pending flag gated by the interrupt enable.
    assign irq = status && irq_en;
endmodule

// File: rtl/itt_checker.sv
// Cycle-level property checks for the interval tick timer, bound into
// every instance of the top module. Observes internal nets only.
module itt_checker #(
    parameter int CNT_W  = 20,
    parameter int PER_W  = 12,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wrap,
    input logic              ack,
    input logic              enable,
    input logic              irq_en,
    input logic              status,
    input logic [PER_W-1:0]  periods,
    input logic [CNT_W-1:0]  value,
    input logic [CNT_W-1:0]  interval,
    input logic              irq,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr
);
    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(value));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (value < interval)) |=> (value == CNT_W'($past(value) + 1'b1)));

    // R4
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(tick));

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((periods == PER_MAX) && !ack) |=> (periods == PER_MAX));

    // R6
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> (!status && (periods == '0)));

    // R6
    ack_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && wrap) |=> (status && (periods == PER_W'(1))));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && (value == '0)) |=> (value == '0));

    // R12
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr != '0)) |=> ($stable(interval) && $stable(enable) && $stable(irq_en)));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind interval_tick_timer itt_checker #(
    .CNT_W  (CNT_W),
    .PER_W  (PER_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wrap     (wrap),
    .ack      (ack),
    .enable   (enable),
    .irq_en   (irq_en),
    .status   (status),
    .periods  (periods),
    .value    (value),
    .interval (interval),
    .irq      (irq),
    .wr_en    (wr_en),
    .addr     (addr)
);

// File: tb/interval_tick_timer_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of intervals and expected period
// lengths, then directed tests for reset, saturation, stop and update.
module interval_tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Interval value and expected cycles from the enabling write edge
    // to the first irq, counting that edge: 16*(interval+1)+1.
    localparam int NVEC = 5;
    localparam int VEC [NVEC][2] = '{
        '{0, 17}, '{1, 33}, '{3, 65}, '{7, 129}, '{12, 209}
    };

    interval_tick_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] mode_word(bit en, bit ien, int ival);
        return {6'd0, ien, en, 4'd0, 20'(ival)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // All bus tasks start and end just after a falling edge.
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    // Poll the side-effect-free window until the counter reads zero.
    task automatic wait_zero(output logic [31:0] last, output int maxv);
        maxv = 0;
        for (int i = 0; i < 400; i++) begin
            bus_read(4'hC, last);
            if (int'(last[19:0]) > maxv) maxv = int'(last[19:0]);
            if (last[19:0] == 20'd0) break;
        end
    endtask

    initial begin
        #(20ns * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        int maxv;

        step(4);
        rst_n = 1'b1;

        // R1: reset state of all registers and the interrupt
        bus_read(4'h0, d); check(d == 0, "R1 mode", d, 0);
        bus_read(4'h4, d); check(d == 0, "R1 status", d, 0);
        bus_read(4'hC, d); check(d == 0, "R1 peek", d, 0);
        bus_read(4'h8, d); check(d == 0, "R1 ack", d, 0);
        check(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);

        // R2: mode readback keeps only interval and enable bits
        bus_write(4'h0, 32'hFEF1_2345);
        bus_read(4'h0, d); check(d == 32'h0201_2345, "R2 readback", d, 32'h0201_2345);
        bus_write(4'h0, 32'h0);

        // Vector table: period length, value windows, acknowledge, stop
        for (int v = 0; v < NVEC; v++) begin
            bus_write(4'h0, mode_word(1, 1, VEC[v][0]));
            n = 1;
            while (!irq && n < 1000) begin
                step(1);
                n++;
            end
            // R3 period length (R9 irq raised with enable set)
            check(n == VEC[v][1], "R3 period", n, VEC[v][1]);
            // R5 both windows show one period and a zero counter
            bus_read(4'hC, d); check(d == {12'd1, 20'd0}, "R5 peek", d, {12'd1, 20'd0});
            bus_read(4'h8, d); check(d == {12'd1, 20'd0}, "R5 ack", d, {12'd1, 20'd0});
            // R6 acknowledge drops the flag and the level interrupt
            check(irq == 1'b0, "R6 irq after ack", {31'd0, irq}, 0);
            bus_write(4'h0, mode_word(0, 1, VEC[v][0]));
            wait_zero(d, maxv);
            bus_read(4'h8, d);
        end

        // R8: saturation with the interrupt masked, free-running
        bus_write(4'h0, mode_word(1, 0, 0));
        step(4096 * 16 + 32);
        bus_read(4'hC, d); check(d == {12'hFFF, 20'd0}, "R8 saturate", d, {12'hFFF, 20'd0});
        // R9 masked flag does not reach irq
        check(irq == 1'b0, "R9 masked", {31'd0, irq}, 0);
        bus_write(4'h0, 32'h0);
        bus_read(4'h4, d); check(d == 1, "R4 flag held", d, 1);

        // R12: writes to read-only offsets change nothing
        bus_write(4'h4, 32'h0);
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_write(4'hC, 32'h0000_0123);
        bus_read(4'h4, d); check(d == 1, "R12 status", d, 1);
        bus_read(4'h0, d); check(d == 0, "R12 mode", d, 0);
        // R7: repeated peeks leave count and flag in place
        bus_read(4'hC, d); check(d == {12'hFFF, 20'd0}, "R7 peek 1", d, {12'hFFF, 20'd0});
        bus_read(4'hC, d); check(d == {12'hFFF, 20'd0}, "R7 peek 2", d, {12'hFFF, 20'd0});
        // R9: unmasking a pending flag raises the level
        bus_write(4'h0, mode_word(0, 1, 0));
        check(irq == 1'b1, "R9 level", {31'd0, irq}, 1);
        bus_read(4'h8, d); check(d == {12'hFFF, 20'd0}, "R6 ack value", d, {12'hFFF, 20'd0});
        check(irq == 1'b0, "R9 drop", {31'd0, irq}, 0);
        bus_read(4'h4, d); check(d == 0, "R6 flag clear", d, 0);
        bus_read(4'hC, d); check(d == 0, "R6 count clear", d, 0);

        // R10: disabling mid-period runs on to zero, then holds
        bus_write(4'h0, mode_word(1, 0, 9));
        step(100);
        bus_read(4'hC, d); check(d == 32'd6, "R3 live value", d, 6);
        bus_write(4'h0, mode_word(0, 0, 9));
        wait_zero(d, maxv);
        check(maxv == 9, "R10 runs on", maxv, 9);
        check(d == {12'd1, 20'd0}, "R10 final wrap", d, {12'd1, 20'd0});
        step(64);
        bus_read(4'hC, d); check(d == {12'd1, 20'd0}, "R10 stays stopped", d, {12'd1, 20'd0});
        bus_read(4'h8, d);

        // R11: lowering the interval below the counter wraps at next tick
        bus_write(4'h0, mode_word(1, 1, 50));
        step(100);
        bus_write(4'h0, mode_word(1, 1, 2));
        n = 1;
        while (!irq && n < 1000) begin
            step(1);
            n++;
        end
        check(n == 12, "R11 early wrap", n, 12);
        bus_read(4'hC, d); check(d == {12'd1, 20'd0}, "R11 value", d, {12'd1, 20'd0});
        bus_write(4'h0, mode_word(0, 0, 2));
        wait_zero(d, maxv);
        bus_read(4'h8, d);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule